// File: doc/BRIEF.md
# Shared-Buffer USB IN Endpoint Responder

This block decides how a USB device function answers an IN token aimed at endpoint 1 or endpoint 2. Both endpoints draw on one set of transmit data registers and one control register. A select bit in the control register gives the buffer to one endpoint at a time. The block answers each accepted token with one of three things:

- a data packet: a DATA0 or DATA1 PID, then the payload bytes, then a CRC-16;
- a single NAK handshake byte;
- a single STALL handshake byte.

The answer leaves as a byte stream towards a serializer. NRZI coding, bit stuffing, token decoding and address matching happen elsewhere.

Software loads the buffer and the control register through a simple register port. Software owns the sequence bit that picks DATA0 or DATA1; hardware never changes it. When the host acknowledges a data packet, the block raises a pending flag and drops the transmit enable. Until software clears the flag and re-arms the enable, further INs get a NAK. If no acknowledge arrives, the same packet is offered again on the next IN.

Top module: `usb_in_shared_ep`

## Requirements
- R1: After reset, every register reads 0, `tx_pend` is 0 and `out_valid` is 0.
- R2: Register map:
  - addresses 0..7 are the data bytes, read and written as written;
  - address 8 is control: bit 7 sequence, bit 6 endpoint select (0 = endpoint 1, 1 = endpoint 2), bit 5 transmit enable, bit 4 always reads 0, bits 3:0 byte count;
  - address 9 reads the pending flag in bit 0, and writing 1 to bit 0 clears it.
- R3: For a token to an enabled endpoint whose stall input is 1, the only byte sent is 0x1E (STALL), with `out_last` high. This holds whatever the other conditions are.
- R4: A token to a disabled endpoint, or to any endpoint number other than 1 or 2, produces no output.
- R5: The block answers with data when all of these hold:
  - the endpoint is enabled and not stalled;
  - pending is 0;
  - transmit enable is 1;
  - select names that endpoint.

  The first byte appears on the cycle after the token. It is 0xC3 (DATA0) when the sequence bit is 0 and 0x4B (DATA1) when it is 1.
- R6: An enabled, unstalled endpoint that misses any other data condition, including a select bit naming the other endpoint, gets the single byte 0x5A (NAK).
- R7: The payload is the data bytes from address 0 upward. Their number is the byte count, and counts above 8 are sent as 8.
- R8: Two CRC bytes follow the payload, low byte first. The CRC is CRC-16 over the payload: polynomial x^16+x^15+x^2+1, processed LSB first, initial value 0xFFFF, result inverted.
- R9: A `host_ack` pulse after a data packet sets pending and clears transmit enable. Without an acknowledge, both stay unchanged and the next IN receives an identical packet.
- R10: The sequence bit changes only through a control register write.
- R11: A token that arrives while `out_valid` is high is ignored.
- R12: A response is a run of one byte per cycle with `out_last` on its final byte, and `out_valid` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tok_valid | input | 1 | IN token strobe |
| tok_ep | input | 4 | Endpoint number of the token |
| ep1_en | input | 1 | Endpoint 1 enabled |
| ep1_stall | input | 1 | Endpoint 1 stalled |
| ep2_en | input | 1 | Endpoint 2 enabled |
| ep2_stall | input | 1 | Endpoint 2 stalled |
| host_ack | input | 1 | Host acknowledged the last data packet |
| tx_pend | output | 1 | Transmit-pending flag |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Packet byte to the serializer |
| out_last | output | 1 | Final byte of the response |

## Verification
The bench builds the block with its default eight-byte buffer, so the four-bit count field can exceed the buffer size. This makes the clamp from counts 9..15 down to 8 reachable, as well as the zero-length packet whose CRC bytes are both 0x00. With a buffer of eight bytes, the longest response is 11 bytes. That is long enough to inject a second token in the middle of a packet and to see the full CRC path over every buffer byte.

// File: rtl/usb_in_shared_ep.sv
module usb_in_shared_ep #(
  parameter int BUF_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tok_valid,
  input  logic [3:0] tok_ep,
  input  logic       ep1_en,
  input  logic       ep1_stall,
  input  logic       ep2_en,
  input  logic       ep2_stall,
  input  logic       host_ack,
  output logic       tx_pend,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_last
);
  localparam int IW = $clog2(BUF_BYTES + 3);
  localparam int BW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
  localparam logic [3:0] CTRL_ADDR = 4'd8;
  localparam logic [3:0] STAT_ADDR = 4'd9;
  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_NAK   = 8'h5A;
  localparam logic [7:0] PID_STALL = 8'h1E;

  logic [7:0]    dbuf [BUF_BYTES];
  logic          seq_q, sel_q, txe_q, pend_q, busy_q, is_data_q, wait_q;
  logic [3:0]    cnt_q;
  logic [7:0]    pid_q;
  logic [IW-1:0] idx_q, plen_q, pidx, eff_cnt, last_idx;
  logic [15:0]   crc_q;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  wire ep1_hit = (tok_ep == 4'd1) && ep1_en;
  wire ep2_hit = (tok_ep == 4'd2) && ep2_en;
  wire stalled = ep1_hit ? ep1_stall : ep2_stall;
  wire sel_ok  = ep1_hit ? !sel_q : sel_q;
  wire ready   = !pend_q && txe_q && sel_ok;
  wire accept  = tok_valid && !busy_q && (ep1_hit || ep2_hit);

  assign eff_cnt  = (int'(cnt_q) > BUF_BYTES) ? IW'(BUF_BYTES) : IW'(cnt_q);
  assign last_idx = is_data_q ? plen_q + IW'(2) : '0;
  assign pidx     = idx_q - IW'(1);

  assign tx_pend   = pend_q;
  assign out_valid = busy_q;
  assign out_last  = busy_q && (idx_q == last_idx);

  always_comb begin
    if (idx_q == '0)                out_byte = pid_q;
    else if (idx_q <= plen_q)       out_byte = dbuf[pidx[BW-1:0]];
    else if (idx_q == plen_q + IW'(1)) out_byte = ~crc_q[7:0];
    else                            out_byte = ~crc_q[15:8];
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (int'(reg_addr) < BUF_BYTES)  reg_rdata = dbuf[reg_addr[BW-1:0]];
    else if (reg_addr == CTRL_ADDR)  reg_rdata = {seq_q, sel_q, txe_q, 1'b0, cnt_q};
    else if (reg_addr == STAT_ADDR)  reg_rdata = {7'd0, pend_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) dbuf[i] <= 8'h00;
      {seq_q, sel_q, txe_q, pend_q, busy_q, is_data_q, wait_q} <= '0;
      cnt_q <= '0; pid_q <= '0; idx_q <= '0; plen_q <= '0; crc_q <= 16'hFFFF;
    end else begin
      if (reg_we) begin
        if (int'(reg_addr) < BUF_BYTES) dbuf[reg_addr[BW-1:0]] <= reg_wdata;
        else if (reg_addr == CTRL_ADDR) begin
          seq_q <= reg_wdata[7]; sel_q <= reg_wdata[6];
          txe_q <= reg_wdata[5]; cnt_q <= reg_wdata[3:0];
        end else if (reg_addr == STAT_ADDR && reg_wdata[0]) pend_q <= 1'b0;
      end
      if (accept) begin
        busy_q    <= 1'b1;
        idx_q     <= '0;
        crc_q     <= 16'hFFFF;
        wait_q    <= 1'b0;
        is_data_q <= !stalled && ready;
        plen_q    <= (!stalled && ready) ? eff_cnt : '0;
        pid_q     <= stalled ? PID_STALL : !ready ? PID_NAK : seq_q ? PID_DATA1 : PID_DATA0;
      end else if (busy_q) begin
        idx_q <= idx_q + IW'(1);
        if (is_data_q && idx_q != '0 && idx_q <= plen_q) crc_q <= crc_step(crc_q, out_byte);
        if (out_last) begin
          busy_q <= 1'b0;
          wait_q <= is_data_q;
        end
      end
      if (host_ack && wait_q) begin
        pend_q <= 1'b1;
        txe_q  <= 1'b0;
        wait_q <= 1'b0;
      end
    end
  end

  // R3
  stall_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !out_valid && tok_ep == 4'd2 && ep2_en && ep2_stall
    |=> out_valid && out_byte == PID_STALL && out_last);

  // R4
  no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !out_valid && !((tok_ep == 4'd1 && ep1_en) || (tok_ep == 4'd2 && ep2_en))
    |=> !out_valid);

  // R6
  sel_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !out_valid && tok_ep == 4'd2 && ep2_en && !ep2_stall && !sel_q
    |=> out_valid && out_byte == PID_NAK && out_last);

  // R9
  ack_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack && wait_q |=> tx_pend && !txe_q);

  // R12
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  // R12
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);
endmodule

// File: tb/usb_in_shared_ep_tb_top.sv
module usb_in_shared_ep_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0, tok_ep = '0;
  logic       reg_we = 1'b0, tok_valid = 1'b0, host_ack = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata, out_byte;
  logic       ep1_en = 1'b0, ep1_stall = 1'b0, ep2_en = 1'b0, ep2_stall = 1'b0;
  logic       tx_pend, out_valid, out_last;

  usb_in_shared_ep #(.BUF_BYTES(8)) dut_i (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] got [24];
  logic [7:0] expb [24];
  logic [7:0] prev [24];
  int gn, en;
  logic [7:0] mb [8];

  function automatic logic [15:0] mk(int ep, bit e1, bit s1, bit e2, bit s2,
                                     bit sq, bit sl, bit tx, int cnt, int kind);
    logic [1:0] e = ep[1:0];
    logic [3:0] c = cnt[3:0];
    logic [1:0] k = kind[1:0];
    return {e, e1, s1, e2, s2, sq, sl, tx, c, k, 1'b0};
  endfunction

  // kind: 0 none, 1 stall, 2 nak, 3 data
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    mk(2, 0, 0, 1, 0, 0, 1, 1, 3, 3),   // R5 R7 DATA0
    mk(2, 0, 0, 1, 0, 1, 1, 1, 8, 3),   // R5 R8 DATA1 full
    mk(2, 0, 0, 1, 0, 0, 0, 1, 4, 2),   // R6 select mismatch
    mk(2, 0, 0, 1, 1, 0, 0, 0, 4, 1),   // R3 stall
    mk(2, 1, 0, 0, 0, 0, 1, 1, 4, 0),   // R4 disabled
    mk(1, 1, 0, 0, 0, 0, 0, 1, 0, 3),   // R8 zero length
    mk(1, 1, 0, 0, 0, 1, 0, 1, 12, 3),  // R7 clamp
    mk(1, 1, 0, 1, 0, 0, 1, 1, 4, 2),   // R6 ep1 select mismatch
    mk(1, 1, 0, 0, 0, 0, 0, 0, 4, 2),   // R6 enable clear
    mk(1, 1, 1, 0, 0, 0, 1, 0, 4, 1),   // R3 stall over NAK
    mk(3, 1, 0, 1, 0, 0, 1, 1, 4, 0)    // R4 other endpoint
  };

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic collect(int inject_at);
    gn = 0;
    while (out_valid && gn < 20) begin
      got[gn] = out_byte;
      tok_valid = (gn == inject_at);
      tok_ep = 4'd2;
      gn++;
      if (out_last) break;
      @(negedge clk);
    end
    tok_valid = 1'b0;
  endtask

  task automatic run_tok(logic [3:0] ep, int inject_at);
    @(negedge clk); tok_valid = 1'b1; tok_ep = ep;
    @(negedge clk); tok_valid = 1'b0;
    collect(inject_at);
  endtask

  function automatic logic [15:0] crc16(int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ mb[i][b]) c = (c >> 1) ^ 16'hA001;
        else                 c = c >> 1;
      end
    return ~c;
  endfunction

  task automatic build_exp(int kind, bit sq, int cnt);
    int n;
    logic [15:0] c;
    en = 0;
    if (kind == 1) begin expb[0] = 8'h1E; en = 1; end
    if (kind == 2) begin expb[0] = 8'h5A; en = 1; end
    if (kind == 3) begin
      n = (cnt > 8) ? 8 : cnt;
      expb[0] = sq ? 8'h4B : 8'hC3;
      for (int i = 0; i < n; i++) expb[i+1] = mb[i];
      c = crc16(n);
      expb[n+1] = c[7:0];
      expb[n+2] = c[15:8];
      en = n + 3;
    end
  endtask

  task automatic cmp_pkt(string req);
    chk(gn == en, req, gn, en);
    for (int i = 0; i < en && i < gn; i++) chk(got[i] == expb[i], req, got[i], expb[i]);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(out_valid == 1'b0 && tx_pend == 1'b0, "R1", {out_valid, tx_pend}, 0);
    rd(4'd8, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(4'd3, v); chk(v == 8'h00, "R1 data", v, 0);
    rd(4'd9, v); chk(v == 8'h00, "R1 status", v, 0);

    // R2 register map
    for (int i = 0; i < 8; i++) begin
      mb[i] = 8'h35 + 8'(i * 29);
      wr(4'(i), mb[i]);
    end
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v); chk(v == mb[i], "R2 data", v, mb[i]);
    end
    wr(4'd8, 8'hFF); rd(4'd8, v); chk(v == 8'hEF, "R2 ctrl bit4", v, 8'hEF);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [15:0] t = VEC[k];
      {ep1_en, ep1_stall, ep2_en, ep2_stall} = t[13:10];
      wr(4'd8, {t[9], t[8], t[7], 1'b0, t[6:3]});
      run_tok({2'b00, t[15:14]}, -1);
      build_exp(int'(t[2:1]), t[9], int'(t[6:3]));
      cmp_pkt($sformatf("R3-6 vec%0d", k));
      @(negedge clk);
      chk(!out_valid, "R12 idle after", out_valid, 0);
    end

    // R9 ack sets pending and clears enable; R10 seq kept
    {ep1_en, ep1_stall, ep2_en, ep2_stall} = 4'b0010;
    wr(4'd8, 8'hE2);
    run_tok(4'd2, -1);
    build_exp(3, 1'b1, 2); cmp_pkt("R9 data before ack");
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); host_ack = 1'b0;
    chk(tx_pend == 1'b1, "R9 pend set", tx_pend, 1);
    rd(4'd8, v); chk(v == 8'hC2, "R9 R10 ctrl after ack", v, 8'hC2);
    wr(4'd8, 8'hE2);
    run_tok(4'd2, -1);
    build_exp(2, 1'b0, 0); cmp_pkt("R6 pending NAK");
    wr(4'd9, 8'h01);
    chk(tx_pend == 1'b0, "R2 pend clear", tx_pend, 0);

    // R9 no ack: same packet again
    run_tok(4'd2, -1);
    for (int i = 0; i < gn; i++) prev[i] = got[i];
    build_exp(3, 1'b1, 2); cmp_pkt("R9 first offer");
    repeat (2) @(negedge clk);
    run_tok(4'd2, -1);
    for (int i = 0; i < en; i++) expb[i] = prev[i];
    cmp_pkt("R9 resend identical");
    chk(tx_pend == 1'b0, "R9 no ack pend", tx_pend, 0);
    rd(4'd8, v); chk(v == 8'hE2, "R10 seq untouched", v, 8'hE2);

    // R11 token during packet ignored
    wr(4'd8, 8'h68);
    run_tok(4'd2, 3);
    build_exp(3, 1'b0, 8); cmp_pkt("R11 R8 full packet");
    @(negedge clk);
    chk(!out_valid, "R11 no second response", out_valid, 0);
    e = crc16(8);
    chk(got[10] == e[15:8], "R8 crc high", got[10], e[15:8]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule